// File: doc/BRIEF.md
# ADC Command-Queue Scan Controller

This block drives an analog-to-digital converter from a table of command words. Each table entry names one input channel. It also holds two marker bits: one that halts the scan after that entry, and one that ends the queue there. The table can hold one queue or two. Queue 1 always begins at entry 0. Queue 2 begins at a table index that the host programs. Each queue has its own trigger input and its own scan mode: off, run once, or run on every trigger.

When a queue is triggered, the controller walks its entries in table order. For each entry it raises a conversion request that carries the channel, and it holds the request until the converter reports completion. The returned result is written into a result table at the same index as the command that produced it. Queue 1 takes precedence over queue 2. A queue 1 trigger that arrives while queue 2 is converting is served once that conversion finishes. Queue 2 then carries on from its next entry.

A host write port loads the command table and a configuration word, and clears the sticky status flags. Results are read back through an asynchronous read port.

Top module: `adc_qscan_ctrl`

## Requirements
- R1: After reset, conv_req is 0 and all four bits of stat_flags are 0.
- R2: A conversion request presents the channel held in bits [5:0] of the command entry. conv_req and conv_chan stay unchanged until conv_done is seen.
- R3: A result returned on conv_done is stored at the result index equal to the table index of the command being converted, and is readable on res_rdata.
- R4: Queue 1 converts entries in ascending order from index 0. It stops after an entry whose end marker (bit 7) is set, and then sets its complete flag (stat_flags bit 1).
- R5: Queue 2 starts at the programmed start index (configuration bits [9:4]). It stops after an entry with bit 7 set, or after the last table entry, and then sets its complete flag (stat_flags bit 3).
- R6: While queue 2 is enabled with a non-zero start index, queue 1 ends after the entry just below that start index, even when that entry has no end marker.
- R7: After converting an entry whose pause bit (bit 6) is set, a queue halts and sets its pause flag (bit 0 for queue 1, bit 2 for queue 2). Its next trigger resumes at the following entry.
- R8: In run-once mode (mode code 1), triggers that arrive after the queue completes are ignored until the configuration word is written again.
- R9: In run-on-every-trigger mode (mode code 2), the trigger that follows a completion restarts the queue at its first entry.
- R10: With mode code 0 (or 3) a queue ignores its trigger. Queue 1's mode is in configuration bits [1:0] and queue 2's mode is in bits [3:2].
- R11: A queue 1 trigger that arrives while a queue 2 conversion is in flight is served after that conversion ends. Queue 2 then continues at the entry after the last one it completed.
- R12: A status write clears each stat_flags bit whose host_wdata bit is 1 and leaves the other bits alone. A set event wins over a clear in the same cycle.
- R13: A trigger that arrives while its queue is already running has no effect on the conversion order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_tgt | input | 2 | Write target: 0 command table, 1 configuration, 2 status clear |
| host_addr | input | 6 | Command table index for target 0 |
| host_wdata | input | 16 | Write data |
| trig_q1 | input | 1 | Queue 1 trigger, one-cycle pulse |
| trig_q2 | input | 1 | Queue 2 trigger, one-cycle pulse |
| conv_req | output | 1 | Conversion request, held until conv_done |
| conv_chan | output | 6 | Channel to convert |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | 10 | Conversion result, valid with conv_done |
| res_raddr | input | 6 | Result table read index |
| res_rdata | output | 10 | Result table read data (combinational) |
| stat_flags | output | 4 | {q2 complete, q2 pause, q1 complete, q1 pause} |

## Verification
A trigger is sampled at a rising edge, which marks its queue running. The first request appears at the following edge, so it is two edges after the trigger. A conversion is retired on the edge where conv_done is sampled: the result is written, the status flags are updated and the queue pointer moves on, all on that edge. The next request rises one edge after that. The bench drives every input at falling edges and samples outputs there too, so each value it reads has settled after exactly those register stages. The scoreboard compares request channels as they appear. Flag and result checks are made only after both the expected queue and the converter model have been idle for several cycles.

// File: rtl/qscan_pkg.sv
// Package: shared encodings for the command-queue scan controller.
// Assumes: host target and scan mode codes are fixed by the software view.
package qscan_pkg;
    typedef enum logic [1:0] {
        SCAN_OFF  = 2'd0,
        SCAN_ONCE = 2'd1,
        SCAN_LOOP = 2'd2,
        SCAN_RSVD = 2'd3
    } scan_mode_e;

    localparam logic [1:0] TGT_CMD = 2'd0;
    localparam logic [1:0] TGT_CFG = 2'd1;
    localparam logic [1:0] TGT_CLR = 2'd2;
endpackage

// File: rtl/qscan_mem.sv
// Module: qscan_mem - single write port, asynchronous read port storage.
// Assumes: contents are undefined until written; no reset on the array.
module qscan_mem #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    // Store one word per write strobe.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Read is combinational.
    assign rdata = store[raddr];
endmodule

// File: rtl/qscan_queue.sv
// Module: qscan_queue - per-queue context: pointer, run/armed state, flags.
// Assumes: fin pulses only for a conversion that belongs to this queue, and
// cfg_load arrives one cycle after the configuration registers change.
module qscan_queue import qscan_pkg::*; #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  scan_mode_e       mode,
    input  logic [IDX_W-1:0] first_idx,
    input  logic [IDX_W-1:0] last_idx,
    input  logic             trig,
    input  logic             fin,
    input  logic             fin_pause,
    input  logic             fin_eoq,
    input  logic             clr_pause,
    input  logic             clr_cmp,
    output logic             run,
    output logic [IDX_W-1:0] ptr,
    output logic             flag_pause,
    output logic             flag_cmp
);
    logic armed;
    logic mode_on;

    assign mode_on = (mode == SCAN_ONCE) || (mode == SCAN_LOOP);

    // Queue state update: reconfigure, retire an entry, or start on a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run        <= 1'b0;
            ptr        <= '0;
            armed      <= 1'b0;
            flag_pause <= 1'b0;
            flag_cmp   <= 1'b0;
        end else begin
            if (clr_pause) flag_pause <= 1'b0;
            if (clr_cmp)   flag_cmp   <= 1'b0;
            if (cfg_load) begin
                run   <= 1'b0;
                ptr   <= first_idx;
                armed <= mode_on;
            end else if (fin) begin
                if (fin_eoq || ptr == last_idx) begin
                    run      <= 1'b0;
                    ptr      <= first_idx;
                    flag_cmp <= 1'b1;
                    if (mode != SCAN_LOOP) armed <= 1'b0;
                end else if (fin_pause) begin
                    run        <= 1'b0;
                    ptr        <= ptr + 1'b1;
                    flag_pause <= 1'b1;
                end else begin
                    ptr <= ptr + 1'b1;
                end
            end else if (trig && !run && armed && mode_on) begin
                run <= 1'b1;
            end
        end
    end

    // A queue only starts running because of its own trigger.
    assert_start_on_trig_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(trig));

    // Reaching the end of a queue stops it.
    assert_cmp_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_cmp) |-> !run);

    // A pause point halts the queue.
    assert_pause_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_pause) |-> !run);
endmodule

// File: rtl/adc_qscan_ctrl.sv
// Module: adc_qscan_ctrl - walks two queues in a shared command table,
// issues one conversion at a time and stores results by command index.
// Assumes: the host rewrites the configuration only while no queue runs;
// the converter answers each request with one conv_done pulse.
module adc_qscan_ctrl import qscan_pkg::*; #(
    parameter int DEPTH  = 64,
    parameter int CHAN_W = 6,
    parameter int RES_W  = 10,
    parameter int HOST_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_tgt,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic              trig_q1,
    input  logic              trig_q2,
    output logic              conv_req,
    output logic [CHAN_W-1:0] conv_chan,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic [IDX_W-1:0]  res_raddr,
    output logic [RES_W-1:0]  res_rdata,
    output logic [3:0]        stat_flags
);
    localparam int PAUSE_BIT = CHAN_W;
    localparam int EOQ_BIT   = CHAN_W + 1;
    localparam int CMD_W     = CHAN_W + 2;
    localparam int START_LSB = 4;
    localparam int NQ        = 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    scan_mode_e       mode_r [NQ];
    logic [IDX_W-1:0] q2_start;
    logic             cfg_apply;
    logic             cmd_we, cfg_we, clr_we;
    logic             q2_en;

    logic [NQ-1:0]    q_run, q_fin, q_pause, q_cmp, q_trig;
    logic [IDX_W-1:0] q_ptr   [NQ];
    logic [IDX_W-1:0] q_first [NQ];
    logic [IDX_W-1:0] q_last  [NQ];

    logic             busy, cur_q, cur_pause, cur_eoq, sel_q;
    logic [IDX_W-1:0] cur_idx, sel_ptr;
    logic [CHAN_W-1:0] chan_r;
    logic [CMD_W-1:0] cmd_rd;

    assign cmd_we = host_we && (host_tgt == TGT_CMD);
    assign cfg_we = host_we && (host_tgt == TGT_CFG);
    assign clr_we = host_we && (host_tgt == TGT_CLR);
    assign q_trig = {trig_q2, trig_q1};

    // Configuration registers; apply pulse follows one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r[0] <= SCAN_OFF;
            mode_r[1] <= SCAN_OFF;
            q2_start  <= '0;
            cfg_apply <= 1'b0;
        end else begin
            cfg_apply <= cfg_we;
            if (cfg_we) begin
                mode_r[0] <= scan_mode_e'(host_wdata[1:0]);
                mode_r[1] <= scan_mode_e'(host_wdata[3:2]);
                q2_start  <= host_wdata[START_LSB +: IDX_W];
            end
        end
    end

    // Queue bounds: queue 1 stops below queue 2's start when queue 2 is live.
    assign q2_en      = (mode_r[1] == SCAN_ONCE) || (mode_r[1] == SCAN_LOOP);
    assign q_first[0] = '0;
    assign q_last[0]  = (q2_en && q2_start != '0) ? q2_start - 1'b1 : LAST_IDX;
    assign q_first[1] = q2_start;
    assign q_last[1]  = LAST_IDX;

    // One context per queue.
    for (genvar g = 0; g < NQ; g++) begin : g_queue
        assign q_fin[g] = busy && conv_done && (cur_q == 1'(g));
        qscan_queue #(.IDX_W(IDX_W)) queue_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_load  (cfg_apply),
            .mode      (mode_r[g]),
            .first_idx (q_first[g]),
            .last_idx  (q_last[g]),
            .trig      (q_trig[g]),
            .fin       (q_fin[g]),
            .fin_pause (cur_pause),
            .fin_eoq   (cur_eoq),
            .clr_pause (clr_we && host_wdata[2*g]),
            .clr_cmp   (clr_we && host_wdata[2*g+1]),
            .run       (q_run[g]),
            .ptr       (q_ptr[g]),
            .flag_pause(q_pause[g]),
            .flag_cmp  (q_cmp[g])
        );
    end

    // Queue 1 wins whenever it is running.
    assign sel_q   = !q_run[0];
    assign sel_ptr = q_ptr[sel_q];

    qscan_mem #(.WIDTH(CMD_W), .DEPTH(DEPTH)) cmd_tbl_i (
        .clk  (clk),
        .we   (cmd_we),
        .waddr(host_addr),
        .wdata(host_wdata[CMD_W-1:0]),
        .raddr(sel_ptr),
        .rdata(cmd_rd)
    );

    qscan_mem #(.WIDTH(RES_W), .DEPTH(DEPTH)) res_tbl_i (
        .clk  (clk),
        .we   (busy && conv_done),
        .waddr(cur_idx),
        .wdata(conv_result),
        .raddr(res_raddr),
        .rdata(res_rdata)
    );

    // Issue/retire: latch the selected command, hold until the converter answers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cur_q     <= 1'b0;
            cur_idx   <= '0;
            cur_pause <= 1'b0;
            cur_eoq   <= 1'b0;
            chan_r    <= '0;
        end else if (busy) begin
            if (conv_done) busy <= 1'b0;
        end else if (|q_run) begin
            busy      <= 1'b1;
            cur_q     <= sel_q;
            cur_idx   <= sel_ptr;
            chan_r    <= cmd_rd[CHAN_W-1:0];
            cur_pause <= cmd_rd[PAUSE_BIT];
            cur_eoq   <= cmd_rd[EOQ_BIT];
        end
    end

    assign conv_req   = busy;
    assign conv_chan  = chan_r;
    assign stat_flags = {q_cmp[1], q_pause[1], q_cmp[0], q_pause[0]};

    // Request and channel stay put until completion.
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_done) |=> (conv_req && $stable(conv_chan)));

    // A running queue 1 is always chosen over queue 2.
    assert_q1_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(q_run[0])) |-> (cur_q == 1'b0));
endmodule

// File: tb/adc_qscan_ctrl_tb_top.sv
// Bench: scoreboard of expected request channels; a converter model pops and
// compares each request, answers after a fixed latency, and records results.
module adc_qscan_ctrl_tb_top;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [1:0] host_tgt = 2'd0;
    logic [5:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic       trig_q1 = 1'b0, trig_q2 = 1'b0;
    logic       conv_req;
    logic [5:0] conv_chan;
    logic       conv_done = 1'b0;
    logic [9:0] conv_result = '0;
    logic [5:0] res_raddr = '0;
    logic [9:0] res_rdata;
    logic [3:0] stat_flags;

    int checks = 0, fails = 0;
    int exp_q[$];
    logic [9:0] res_model [64];
    bit  pending = 1'b0;
    int  cnt = 0, req_count = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    adc_qscan_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_tgt(host_tgt),
        .host_addr(host_addr), .host_wdata(host_wdata), .trig_q1(trig_q1),
        .trig_q2(trig_q2), .conv_req(conv_req), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_result(conv_result), .res_raddr(res_raddr),
        .res_rdata(res_rdata), .stat_flags(stat_flags)
    );

    function automatic logic [5:0] chan_of(int idx);
        return 6'((idx * 5 + 3) % 64);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Converter model and monitor: compare each new request with the scoreboard.
    always @(negedge clk) begin
        if (conv_done) begin
            conv_done <= 1'b0;
            pending   <= 1'b0;
        end else if (pending) begin
            if (cnt <= 1) begin
                conv_result <= {conv_chan, 4'(req_count)};
                res_model[conv_chan] = {conv_chan, 4'(req_count)};
                conv_done <= 1'b1;
            end
            cnt <= cnt - 1;
        end else if (conv_req) begin
            req_count++;
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2 actual=unexpected request chan %0d expected=no request", conv_chan);
            end else begin
                check("R2 request channel", 32'(conv_chan), 32'(exp_q.pop_front()));
            end
            pending <= 1'b1;
            cnt     <= LAT;
        end
    end

    task automatic host_write(logic [1:0] tgt, int addr, logic [15:0] data);
        @(negedge clk);
        host_we = 1'b1; host_tgt = tgt; host_addr = 6'(addr); host_wdata = data;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic write_cmd(int idx, bit pause, bit eoq);
        host_write(2'd0, idx, {8'd0, eoq, pause, chan_of(idx)});
    endtask

    task automatic pulse(bit t1, bit t2);
        @(negedge clk);
        trig_q1 = t1; trig_q2 = t2;
        @(negedge clk);
        trig_q1 = 1'b0; trig_q2 = 1'b0;
    endtask

    task automatic expect_idx(int idx);
        exp_q.push_back(int'(chan_of(idx)));
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (exp_q.size() != 0 || pending);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_res(string req, int idx);
        @(negedge clk);
        res_raddr = 6'(idx);
        #1;
        check(req, 32'(res_rdata), 32'(res_model[chan_of(idx)]));
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // Stimulus driver.
    initial begin
        int base;
        repeat (3) @(negedge clk);
        check("R1 conv_req after reset", 32'(conv_req), 0);
        check("R1 flags after reset", 32'(stat_flags), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) write_cmd(i, 1'b0, 1'b0);
        write_cmd(1, 1'b1, 1'b0);
        write_cmd(2, 1'b0, 1'b1);

        // R7 pause, R4 completion, R3 results: queue 1 run once.
        host_write(2'd1, 0, 16'h0001);
        expect_idx(0); expect_idx(1);
        pulse(1'b1, 1'b0);
        wait_idle();
        check("R7 pause flag after sub-queue", 32'(stat_flags), 32'h1);
        expect_idx(2);
        pulse(1'b1, 1'b0);
        wait_idle();
        check("R4 complete flag at end marker", 32'(stat_flags), 32'h3);
        check_res("R3 result index 0", 0);
        check_res("R3 result index 1", 1);
        check_res("R3 result index 2", 2);

        // R8: run-once queue ignores a further trigger.
        base = req_count;
        pulse(1'b1, 1'b0);
        repeat (12) @(negedge clk);
        check("R8 no request after single scan", 32'(req_count), 32'(base));

        // R12: selective write-one-to-clear.
        host_write(2'd2, 0, 16'h0001);
        check("R12 clear pause only", 32'(stat_flags), 32'h2);
        host_write(2'd2, 0, 16'h000F);
        check("R12 clear all", 32'(stat_flags), 32'h0);

        // R9: continuous mode restarts at the first entry.
        write_cmd(1, 1'b0, 1'b0);
        host_write(2'd1, 0, 16'h0002);
        expect_idx(0); expect_idx(1); expect_idx(2);
        pulse(1'b1, 1'b0);
        wait_idle();
        expect_idx(0); expect_idx(1); expect_idx(2);
        pulse(1'b1, 1'b0);
        wait_idle();
        check("R9 complete flag in continuous mode", 32'(stat_flags), 32'h2);
        host_write(2'd2, 0, 16'h000F);

        // R11, R13, R6: queue 1 preempts queue 2 between conversions.
        write_cmd(2, 1'b0, 1'b0);
        write_cmd(6, 1'b0, 1'b1);
        host_write(2'd1, 0, 16'h0045);
        expect_idx(4);
        expect_idx(0); expect_idx(1); expect_idx(2); expect_idx(3);
        expect_idx(5); expect_idx(6);
        base = req_count;
        pulse(1'b0, 1'b1);
        wait (req_count == base + 1);
        pulse(1'b1, 1'b1);
        wait_idle();
        check("R11 R6 both queues complete", 32'(stat_flags), 32'hA);
        check("R13 request count unchanged by extra trigger", 32'(req_count), 32'(base + 7));
        check_res("R3 result index 4", 4);
        check_res("R3 result index 6", 6);
        host_write(2'd2, 0, 16'h000F);

        // R5: queue 2 runs to the last table entry.
        host_write(2'd1, 0, 16'((1 << 2) | (61 << 4)));
        expect_idx(61); expect_idx(62); expect_idx(63);
        pulse(1'b0, 1'b1);
        wait_idle();
        check("R5 queue 2 complete at table end", 32'(stat_flags), 32'h8);
        check_res("R3 result index 63", 63);

        // R10: disabled queues ignore triggers.
        host_write(2'd1, 0, 16'h0000);
        base = req_count;
        pulse(1'b1, 1'b1);
        repeat (12) @(negedge clk);
        check("R10 no request when disabled", 32'(req_count), 32'(base));

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule